// File: doc/BRIEF.md
# Per-Pin Multiplexed GPIO Port

This block owns one 32-pin I/O port. Each pin is routed to its pad from one of three owners: a primary peripheral, an alternate peripheral, or a general-purpose I/O submodule. When a pin is in general-purpose mode, a per-pin selector picks what drives the pad. The choices are one of three peripheral function-block signals (A, B, C) or a bit of a data register. In that mode the pad output enable follows a per-pin direction bit.

Two more per-pin selectors choose what each pin feeds back into function-block inputs A and B. The choices are the synchronised pad level, an interrupt status bit supplied from outside, a constant low, or a constant high. The block also provides a per-pin pull-up enable and a readback of the synchronised pad levels.

Software configures the port through a word-addressed register bus. A write takes one clock cycle. A read is combinational from the address. Every setting clears to zero on reset, which leaves each pin on its primary function with the pull-up off.

Top module: `pmux_port`

## Requirements
- R1: After reset, every writable register reads 0. `pad_out`/`pad_oe` equal `pri_out`/`pri_oe`, and `pad_pu` is 0.
- R2: The pin function is decided per pin from two bits. If the use-GPIO bit (address 8) is 1, the pin is in general-purpose mode, whatever the alternate-select bit says. Otherwise the alternate-select bit (address 9) picks the source: 1 gives `alt_out`/`alt_oe` and 0 gives `pri_out`/`pri_oe`.
- R3: In general-purpose mode, `pad_oe` of a pin equals its direction bit (address 0; 1 = output). Outside that mode the direction bit has no effect.
- R4: In general-purpose mode, the 2-bit output-source field of a pin drives `pad_out`: 0 = `fba_out`, 1 = `fbb_out`, 2 = `fbc_out`, 3 = data register bit (address 7). Outside that mode, the field and the data register have no effect.
- R5: Each 2-bit per-pin field is held in a word pair. Pins 0..15 are in the low word and pins 16..31 in the high word, with pin n at bits [2m+1:2m] where m = n mod 16. The word addresses are: output source low 1 / high 2, A-input source low 3 / high 4, B-input source low 5 / high 6.
- R6: The A-input and B-input source fields drive `fba_in`/`fbb_in`: 0 = synchronised pad level, 1 = `irq_status` bit, 2 = constant 0, 3 = constant 1.
- R7: A change on `pad_in` reaches the pad-status readback (address 10) and the pad-level path of `fba_in`/`fbb_in` after exactly two rising clock edges.
- R8: `pad_pu` equals the pull-up register (address 12, 1 = enabled) from the edge that writes it.
- R9: Writable registers (addresses 0..9 and 12) read back the last value written. Address 10 reads the synchronised pad levels and address 11 reads `irq_status`. Writes to addresses 10 and 11 are ignored.
- R10: Addresses 13..15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pu | output | 32 | Pad pull-up enable |
| pri_out | input | 32 | Primary peripheral output |
| pri_oe | input | 32 | Primary peripheral output enable |
| alt_out | input | 32 | Alternate peripheral output |
| alt_oe | input | 32 | Alternate peripheral output enable |
| fba_out | input | 32 | Function-block A output per pin |
| fbb_out | input | 32 | Function-block B output per pin |
| fbc_out | input | 32 | Function-block C output per pin |
| fba_in | output | 32 | Function-block A input per pin |
| fbb_in | output | 32 | Function-block B input per pin |
| irq_status | input | 32 | Interrupt status bits from outside the block |

## Verification
The bench walks each pin one at a time through the output-source field. A design that swapped words or misplaced a field would light the wrong pin at the pin 15/16 boundary. Rotating sweeps mix all three functions with every source and direction value. These sweeps catch two faults: a data register or direction bit that leaks into a peripheral-owned pin, and an alternate-select bit that overrides the use-GPIO bit.

Input routing is swept over all four sources for both blocks. A pad edge is sampled after one and after two clock edges, so a synchroniser with the wrong depth shows up. Writes to the read-only and unmapped addresses check that a sloppy decoder does not clobber a live register.

// File: rtl/pmux_pkg.sv
package pmux_pkg;
    localparam logic [3:0] ADDR_DIR     = 4'd0;
    localparam logic [3:0] ADDR_OSRC_LO = 4'd1;
    localparam logic [3:0] ADDR_OSRC_HI = 4'd2;
    localparam logic [3:0] ADDR_ISA_LO  = 4'd3;
    localparam logic [3:0] ADDR_ISA_HI  = 4'd4;
    localparam logic [3:0] ADDR_ISB_LO  = 4'd5;
    localparam logic [3:0] ADDR_ISB_HI  = 4'd6;
    localparam logic [3:0] ADDR_DATA    = 4'd7;
    localparam logic [3:0] ADDR_GUSE    = 4'd8;
    localparam logic [3:0] ADDR_ALTSEL  = 4'd9;
    localparam logic [3:0] ADDR_PADST   = 4'd10;
    localparam logic [3:0] ADDR_IRQST   = 4'd11;
    localparam logic [3:0] ADDR_PULLUP  = 4'd12;
    localparam int         ADDR_LAST    = 12;

    typedef enum logic [1:0] {FN_PRI, FN_ALT, FN_GPIO} pin_fn_e;
    typedef enum logic [1:0] {OSRC_FBA, OSRC_FBB, OSRC_FBC, OSRC_DATA} out_src_e;
    typedef enum logic [1:0] {ISRC_PAD, ISRC_IRQ, ISRC_LOW, ISRC_HIGH} in_src_e;

    function automatic logic route_in(in_src_e s, logic pad, logic irq);
        case (s)
            ISRC_PAD: return pad;
            ISRC_IRQ: return irq;
            ISRC_LOW: return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/pmux_sync.sv
module pmux_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1, stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pmux_regs.sv
module pmux_regs
    import pmux_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NPINS-1:0]   wr_data,
    input  logic [NPINS-1:0]   pad_sync,
    input  logic [NPINS-1:0]   irq_status,
    output logic [NPINS-1:0]   rd_data,
    output logic [NPINS-1:0]   dir_q,
    output logic [NPINS-1:0]   data_q,
    output logic [NPINS-1:0]   guse_q,
    output logic [NPINS-1:0]   altsel_q,
    output logic [NPINS-1:0]   pullup_q,
    output logic [2*NPINS-1:0] osrc_f,
    output logic [2*NPINS-1:0] isa_f,
    output logic [2*NPINS-1:0] isb_f
);
    logic [NPINS-1:0] osrc_lo, osrc_hi, isa_lo, isa_hi, isb_lo, isb_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q    <= '0;
            data_q   <= '0;
            guse_q   <= '0;
            altsel_q <= '0;
            pullup_q <= '0;
            osrc_lo  <= '0;
            osrc_hi  <= '0;
            isa_lo   <= '0;
            isa_hi   <= '0;
            isb_lo   <= '0;
            isb_hi   <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_DIR:     dir_q    <= wr_data;
                ADDR_OSRC_LO: osrc_lo  <= wr_data;
                ADDR_OSRC_HI: osrc_hi  <= wr_data;
                ADDR_ISA_LO:  isa_lo   <= wr_data;
                ADDR_ISA_HI:  isa_hi   <= wr_data;
                ADDR_ISB_LO:  isb_lo   <= wr_data;
                ADDR_ISB_HI:  isb_hi   <= wr_data;
                ADDR_DATA:    data_q   <= wr_data;
                ADDR_GUSE:    guse_q   <= wr_data;
                ADDR_ALTSEL:  altsel_q <= wr_data;
                ADDR_PULLUP:  pullup_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_DIR:     rd_data = dir_q;
            ADDR_OSRC_LO: rd_data = osrc_lo;
            ADDR_OSRC_HI: rd_data = osrc_hi;
            ADDR_ISA_LO:  rd_data = isa_lo;
            ADDR_ISA_HI:  rd_data = isa_hi;
            ADDR_ISB_LO:  rd_data = isb_lo;
            ADDR_ISB_HI:  rd_data = isb_hi;
            ADDR_DATA:    rd_data = data_q;
            ADDR_GUSE:    rd_data = guse_q;
            ADDR_ALTSEL:  rd_data = altsel_q;
            ADDR_PADST:   rd_data = pad_sync;
            ADDR_IRQST:   rd_data = irq_status;
            ADDR_PULLUP:  rd_data = pullup_q;
            default:      rd_data = '0;
        endcase
    end

    // The low word holds pins 0..NPINS/2-1 and the high word the rest,
    // so pin n lands at bits [2n+1:2n] of the concatenation.
    assign osrc_f = {osrc_hi, osrc_lo};
    assign isa_f  = {isa_hi, isa_lo};
    assign isb_f  = {isb_hi, isb_lo};
endmodule

// File: rtl/pmux_pin.sv
module pmux_pin
    import pmux_pkg::*;
(
    input  logic       gpio_sel,
    input  logic       alt_sel,
    input  logic       dir,
    input  logic       data,
    input  logic [1:0] osrc,
    input  logic [1:0] isa,
    input  logic [1:0] isb,
    input  logic       pri_o,
    input  logic       pri_oe,
    input  logic       alt_o,
    input  logic       alt_oe,
    input  logic       fba_o,
    input  logic       fbb_o,
    input  logic       fbc_o,
    input  logic       pad_s,
    input  logic       irq,
    output logic       pad_o,
    output logic       pad_oen,
    output logic       fba_i,
    output logic       fbb_i
);
    pin_fn_e fn;

    always_comb begin
        if (gpio_sel)     fn = FN_GPIO;
        else if (alt_sel) fn = FN_ALT;
        else              fn = FN_PRI;
    end

    always_comb begin
        pad_o   = pri_o;
        pad_oen = pri_oe;
        unique case (fn)
            FN_PRI: begin
                pad_o   = pri_o;
                pad_oen = pri_oe;
            end
            FN_ALT: begin
                pad_o   = alt_o;
                pad_oen = alt_oe;
            end
            FN_GPIO: begin
                pad_oen = dir;
                unique case (out_src_e'(osrc))
                    OSRC_FBA:  pad_o = fba_o;
                    OSRC_FBB:  pad_o = fbb_o;
                    OSRC_FBC:  pad_o = fbc_o;
                    OSRC_DATA: pad_o = data;
                endcase
            end
            default: ;
        endcase
    end

    assign fba_i = route_in(in_src_e'(isa), pad_s, irq);
    assign fbb_i = route_in(in_src_e'(isb), pad_s, irq);
endmodule

// File: rtl/pmux_port.sv
module pmux_port
    import pmux_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pu,
    input  logic [NPINS-1:0]  pri_out,
    input  logic [NPINS-1:0]  pri_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    input  logic [NPINS-1:0]  fba_out,
    input  logic [NPINS-1:0]  fbb_out,
    input  logic [NPINS-1:0]  fbc_out,
    output logic [NPINS-1:0]  fba_in,
    output logic [NPINS-1:0]  fbb_in,
    input  logic [NPINS-1:0]  irq_status
);
    localparam int FW = 2 * NPINS;

    logic [NPINS-1:0] pad_sync, dir_q, data_q, guse_q, altsel_q;
    logic [FW-1:0]    osrc_f, isa_f, isb_f;

    pmux_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst_n(rst_n),
        .d   (pad_in),
        .q   (pad_sync)
    );

    pmux_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wr_data   (bus_wdata),
        .pad_sync  (pad_sync),
        .irq_status(irq_status),
        .rd_data   (bus_rdata),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .guse_q    (guse_q),
        .altsel_q  (altsel_q),
        .pullup_q  (pad_pu),
        .osrc_f    (osrc_f),
        .isa_f     (isa_f),
        .isb_f     (isb_f)
    );

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        pmux_pin u_pin (
            .gpio_sel(guse_q[n]),
            .alt_sel (altsel_q[n]),
            .dir     (dir_q[n]),
            .data    (data_q[n]),
            .osrc    (osrc_f[2*n +: 2]),
            .isa     (isa_f[2*n +: 2]),
            .isb     (isb_f[2*n +: 2]),
            .pri_o   (pri_out[n]),
            .pri_oe  (pri_oe[n]),
            .alt_o   (alt_out[n]),
            .alt_oe  (alt_oe[n]),
            .fba_o   (fba_out[n]),
            .fbb_o   (fbb_out[n]),
            .fbc_o   (fbc_out[n]),
            .pad_s   (pad_sync[n]),
            .irq     (irq_status[n]),
            .pad_o   (pad_out[n]),
            .pad_oen (pad_oe[n]),
            .fba_i   (fba_in[n]),
            .fbb_i   (fbb_in[n])
        );
    end
endmodule

// File: rtl/pmux_port_chk.sv
module pmux_port_chk
    import pmux_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  bus_rdata,
    input logic [NPINS-1:0]  pad_in,
    input logic [NPINS-1:0]  pad_out,
    input logic [NPINS-1:0]  pad_oe,
    input logic [NPINS-1:0]  pad_pu,
    input logic [NPINS-1:0]  pri_out,
    input logic [NPINS-1:0]  alt_out,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  guse_q,
    input logic [NPINS-1:0]  altsel_q
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            age <= 2'd0;
        else if (age != 2'd2)  age <= age + 2'd1;
    end

    AST_PADST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd2 && bus_addr == ADDR_PADST) |-> bus_rdata == $past(pad_in, 2)); // R7

    AST_PULLUP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_PULLUP) |=> pad_pu == $past(bus_wdata)); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) > ADDR_LAST) |-> bus_rdata == '0); // R10

    AST_GPIO_OE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe ^ dir_q) & guse_q) == '0); // R3

    AST_PERIPH_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ ((altsel_q & alt_out) | (~altsel_q & pri_out))) & ~guse_q) == '0); // R2
endmodule

bind pmux_port pmux_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu),
    .pri_out  (pri_out),
    .alt_out  (alt_out),
    .dir_q    (dir_q),
    .guse_q   (guse_q),
    .altsel_q (altsel_q)
);

// File: tb/tb_pmux_port.sv
module tb_pmux_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pu;
    logic [31:0] pri_out = '0, pri_oe = '0, alt_out = '0, alt_oe = '0;
    logic [31:0] fba_out = '0, fbb_out = '0, fbc_out = '0;
    logic [31:0] fba_in, fbb_in;
    logic [31:0] irq_status = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    pmux_port dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pri_out(pri_out), .pri_oe(pri_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .fba_out(fba_out), .fbb_out(fbb_out), .fbc_out(fbc_out),
        .fba_in(fba_in), .fbb_in(fbb_in), .irq_status(irq_status)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] fmask(input logic [63:0] fv, input bit hi);
        logic [31:0] w = '0;
        for (int m = 0; m < 16; m++) w[2*m +: 2] = fv[2*((hi ? 16 : 0) + m) +: 2];
        return w;
    endfunction

    task automatic wr_fields(input logic [3:0] lo_addr, input logic [63:0] fv);
        wr(lo_addr, fmask(fv, 1'b0));
        wr(lo_addr + 4'd1, fmask(fv, 1'b1));
    endtask

    function automatic logic sel_in(input logic [1:0] s, input logic pad, input logic irq);
        case (s)
            2'd0: return pad;
            2'd1: return irq;
            2'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        logic [31:0] r;
        logic [63:0] ofv, afv, bfv;
        logic [31:0] dirv, datav, gusev, altv, exp_o, exp_oe, exp_a, exp_b;

        pri_out = 32'hC3A5_5A3C; pri_oe = 32'h0FF0_33CC;
        alt_out = 32'h9696_6969; alt_oe = 32'hF00F_CC33;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 13; a++) begin
            rd(a[3:0], r);
            chk("R1 reset register", r, 32'h0);
        end
        #1;
        chk("R1 reset pad_out", pad_out, pri_out);
        chk("R1 reset pad_oe", pad_oe, pri_oe);
        chk("R1 reset pad_pu", pad_pu, 32'h0);

        // R9: read back writable registers
        for (int a = 0; a < 13; a++)
            if (a != 10 && a != 11) wr(a[3:0], 32'h0101_0101 * (a + 1) ^ 32'h5A00_00A5);
        for (int a = 0; a < 13; a++)
            if (a != 10 && a != 11) begin
                rd(a[3:0], r);
                chk("R9 readback", r, 32'h0101_0101 * (a + 1) ^ 32'h5A00_00A5);
            end
        // R9: status addresses ignore writes and show live inputs
        pad_in = 32'h1357_9BDF; irq_status = 32'hFACE_0042;
        wr(4'd10, 32'hFFFF_FFFF);
        wr(4'd11, 32'hFFFF_FFFF);
        rd(4'd10, r); chk("R9 pad status", r, 32'h1357_9BDF);
        rd(4'd11, r); chk("R9 irq status", r, 32'hFACE_0042);
        // R10: unmapped addresses
        for (int a = 13; a < 16; a++) wr(a[3:0], 32'hFFFF_FFFF);
        for (int a = 13; a < 16; a++) begin
            rd(a[3:0], r); chk("R10 unmapped read", r, 32'h0);
        end
        for (int a = 0; a < 13; a++)
            if (a != 10 && a != 11) begin
                rd(a[3:0], r);
                chk("R10 unmapped write left register", r, 32'h0101_0101 * (a + 1) ^ 32'h5A00_00A5);
            end
        for (int a = 0; a < 13; a++) if (a != 10 && a != 11) wr(a[3:0], 32'h0);

        // R5: walk the data source over each pin
        fba_out = '0; fbb_out = '0; fbc_out = '0;
        wr(4'd8, 32'hFFFF_FFFF);
        wr(4'd7, 32'hFFFF_FFFF);
        for (int n = 0; n < 32; n++) begin
            ofv = '0;
            ofv[2*n +: 2] = 2'd3;
            wr_fields(4'd1, ofv);
            #1 chk("R5 field position", pad_out, 32'h1 << n);
        end

        // R2 R3 R4: rotating function / source / direction sweep
        for (int k = 0; k < 12; k++) begin
            ofv = '0; dirv = '0; gusev = '0; altv = '0;
            datav = 32'h1234_5678 ^ (k * 32'h0F0F_1357);
            for (int n = 0; n < 32; n++) begin
                ofv[2*n +: 2] = 2'((n / 3 + k) % 4);
                dirv[n]  = 1'(((n >> 1) + k) & 1);
                gusev[n] = ((n + k) % 3) == 2;
                altv[n]  = ((n + k) % 3) == 1 || (gusev[n] && (k % 2 == 1));
            end
            wr_fields(4'd1, ofv);
            wr(4'd0, dirv); wr(4'd7, datav); wr(4'd8, gusev); wr(4'd9, altv);
            fba_out = 32'hAAAA_5555 ^ (k * 32'h0110_2203);
            fbb_out = 32'h3333_CCCC ^ (k * 32'h1001_0330);
            fbc_out = 32'hFF00_00FF ^ (k * 32'h0707_7070);
            for (int n = 0; n < 32; n++) begin
                if (gusev[n]) begin
                    exp_oe[n] = dirv[n];
                    case (ofv[2*n +: 2])
                        2'd0: exp_o[n] = fba_out[n];
                        2'd1: exp_o[n] = fbb_out[n];
                        2'd2: exp_o[n] = fbc_out[n];
                        default: exp_o[n] = datav[n];
                    endcase
                end else if (altv[n]) begin
                    exp_o[n] = alt_out[n]; exp_oe[n] = alt_oe[n];
                end else begin
                    exp_o[n] = pri_out[n]; exp_oe[n] = pri_oe[n];
                end
            end
            #1;
            chk("R2/R4 pad_out sweep", pad_out, exp_o);
            chk("R3 pad_oe sweep", pad_oe, exp_oe);
        end

        // R6: input routing sweep
        for (int k = 0; k < 8; k++) begin
            afv = '0; bfv = '0;
            for (int n = 0; n < 32; n++) begin
                afv[2*n +: 2] = 2'((n + k) % 4);
                bfv[2*n +: 2] = 2'((3 * n + k + 1) % 4);
            end
            wr_fields(4'd3, afv);
            wr_fields(4'd5, bfv);
            pad_in = 32'hDEAD_BEEF ^ (k * 32'h1111_1111);
            irq_status = 32'h5A5A_F0F0 ^ (k * 32'h0303_0C0C);
            repeat (3) @(negedge clk);
            for (int n = 0; n < 32; n++) begin
                exp_a[n] = sel_in(afv[2*n +: 2], pad_in[n], irq_status[n]);
                exp_b[n] = sel_in(bfv[2*n +: 2], pad_in[n], irq_status[n]);
            end
            #1;
            chk("R6 fba_in routing", fba_in, exp_a);
            chk("R6 fbb_in routing", fbb_in, exp_b);
        end

        // R7: two-edge synchroniser latency
        wr_fields(4'd3, 64'h0);
        pad_in = '0;
        bus_addr = 4'd10;
        repeat (3) @(negedge clk);
        pad_in = 32'hFFFF_FFFF;
        @(negedge clk); #1;
        chk("R7 status after one edge", bus_rdata, 32'h0);
        chk("R7 fba_in after one edge", fba_in, 32'h0);
        @(negedge clk); #1;
        chk("R7 status after two edges", bus_rdata, 32'hFFFF_FFFF);
        chk("R7 fba_in after two edges", fba_in, 32'hFFFF_FFFF);

        // R8: pull-up follows its register
        wr(4'd12, 32'h8000_0001);
        #1 chk("R8 pull-up", pad_pu, 32'h8000_0001);
        wr(4'd12, 32'h7FFF_FFFE);
        #1 chk("R8 pull-up", pad_pu, 32'h7FFF_FFFE);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule